// File: doc/BRIEF.md
# Wordclock Lock Window Monitor

This block watches a recovered wordclock against its reference on every reference cycle and reports when the two drift apart. Both wordclocks arrive asynchronous to the fast master clock. Each passes through a two-flop synchroniser and then a rising-edge detector. The block measures the signed distance, in master-clock ticks, between each reference rising edge and the nearest local rising edge. The test applies to each reference cycle on its own, with no averaging across cycles. A distance larger than the tolerance produces a one-cycle error pulse. The tolerance is one 128th of a wordclock period, so `WORD_TICKS/128` ticks in either direction.

Each error pulse reloads a retriggerable hold timer. The unlock status bit stays high while that timer is nonzero. A software poll that runs tens of milliseconds apart therefore cannot miss a short unlock episode. By default the hold length is computed from the master-clock frequency to give 50 ms.

Top module: `wclk_lock_monitor`

## Requirements
- R1: A local rising edge that lags the reference rising edge by 0 to N master-clock ticks (N = WORD_TICKS/128) produces no error pulse.
- R2: A local rising edge that leads the reference rising edge by 1 to N ticks produces no error pulse.
- R3: A local edge that lags by more than N ticks, up to half a period, produces exactly one error pulse per reference period.
- R4: A local edge that leads by more than N ticks, up to half a period, produces exactly one error pulse per reference period.
- R5: With the local wordclock stopped, every reference rising edge produces exactly one error pulse.
- R6: The error pulse `lockErr` is high for exactly one master-clock cycle per failing reference edge.
- R7: `unlockStatus` rises in the same cycle as an error pulse. It falls exactly HOLD_CYCLES cycles after the last pulse.
- R8: An error pulse that arrives while the hold timer is running reloads the timer to its full count. Pulses spaced closer than HOLD_CYCLES therefore keep `unlockStatus` high without a gap.
- R9: An active-low reset clears `lockErr` and `unlockStatus` at once, including while the hold timer is running.
- R10: Without reference rising edges no window test takes place, so no error pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refWclkIn | input | 1 | Reference wordclock, asynchronous |
| locWclkIn | input | 1 | Locally generated aligned wordclock, asynchronous |
| lockErr | output | 1 | One-cycle pulse for each out-of-window reference cycle |
| unlockStatus | output | 1 | Stretched unlock flag for software polling |

## Verification
The bench sweeps the local-to-reference offset in single ticks across both window edges, from ten ticks early to ten ticks late. This separates the last passing offset from the first failing one, on the lagging side and on the leading side. Far offsets near half a period confirm that an edge is matched to the nearest reference edge and not to the neighbouring one. A stopped local clock and a stopped reference show what happens when one clock is missing. A burst of errors followed by clean cycles measures the exact hold length and shows that a retrigger leaves no gap in the status bit.

// File: rtl/wlm_pkg.sv
package wlm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wlm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startWait;  // reference edge seen, no matching local edge yet
    logic errStrobe;  // window closed without a local edge
  } wlm_ctrl_t;

endpackage

// File: rtl/wlm_edge_sync.sv
module wlm_edge_sync #(
  parameter int CHANNELS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] asyncIn,
  output logic [CHANNELS-1:0] riseOut
);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], asyncIn[ch]};
        prevQ <= syncQ[SYNC_STAGES-1];
      end
    end

    assign riseOut[ch] = syncQ[SYNC_STAGES-1] & ~prevQ;
  end

endmodule

// File: rtl/wlm_control.sv
module wlm_control
  import wlm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      refRise,
  input  logic      locRise,
  input  logic      locRecent,
  input  logic      refAtLimit,
  output wlm_ctrl_t ctrl
);

  wlm_state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        // a local edge now or within the window before counts as aligned
        if (refRise && !(locRise || locRecent)) begin
          ctrl.startWait = 1'b1;
          stateNxt       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (locRise) begin
          stateNxt = ST_IDLE;
        end else if (refAtLimit) begin
          ctrl.errStrobe = 1'b1;
          stateNxt       = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wlm_datapath.sv
module wlm_datapath
  import wlm_pkg::*;
#(
  parameter int WIN_TICKS   = 4,
  parameter int HALF_TICKS  = 256,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  wlm_ctrl_t ctrl,
  input  logic      locRise,
  output logic      locRecent,
  output logic      refAtLimit,
  output logic      lockErr,
  output logic      unlockStatus
);

  localparam int AGE_W  = $clog2(HALF_TICKS + 1);
  localparam int REF_W  = $clog2(WIN_TICKS + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  localparam logic [AGE_W-1:0]  AGE_MAX   = AGE_W'(HALF_TICKS);
  localparam logic [AGE_W-1:0]  AGE_WIN   = AGE_W'(WIN_TICKS);
  localparam logic [REF_W-1:0]  REF_LIMIT = REF_W'(WIN_TICKS);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);

  logic [AGE_W-1:0]  locAge;   // ticks since last local edge, saturating
  logic [REF_W-1:0]  refCnt;   // ticks since unmatched reference edge
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 locAge <= AGE_MAX;
    else if (locRise)          locAge <= AGE_W'(1);
    else if (locAge != AGE_MAX) locAge <= locAge + AGE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   refCnt <= '0;
    else if (ctrl.startWait)     refCnt <= REF_W'(1);
    else if (refCnt != REF_LIMIT) refCnt <= refCnt + REF_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockErr <= 1'b0;
      holdCnt <= '0;
    end else begin
      lockErr <= ctrl.errStrobe;
      if (ctrl.errStrobe)    holdCnt <= HOLD_LOAD;
      else if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  assign locRecent    = (locAge <= AGE_WIN);
  assign refAtLimit   = (refCnt == REF_LIMIT);
  assign unlockStatus = (holdCnt != '0);

endmodule

// File: rtl/wclk_lock_monitor.sv
module wclk_lock_monitor
  import wlm_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 24_576_000,
  parameter int WORD_TICKS  = 512,
  parameter int HOLD_MS     = 50,
  parameter int HOLD_CYCLES = (CLK_FREQ_HZ / 1000) * HOLD_MS
) (
  input  logic clk,
  input  logic rstN,
  input  logic refWclkIn,
  input  logic locWclkIn,
  output logic lockErr,
  output logic unlockStatus
);

  localparam int WIN_TICKS  = WORD_TICKS / 128;
  localparam int HALF_TICKS = WORD_TICKS / 2;

  logic [1:0] rise;
  wlm_ctrl_t  ctrl;
  logic       locRecent;
  logic       refAtLimit;

  wlm_edge_sync #(.CHANNELS(2), .SYNC_STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({locWclkIn, refWclkIn}),
    .riseOut (rise)
  );

  wlm_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refRise    (rise[0]),
    .locRise    (rise[1]),
    .locRecent  (locRecent),
    .refAtLimit (refAtLimit),
    .ctrl       (ctrl)
  );

  wlm_datapath #(
    .WIN_TICKS   (WIN_TICKS),
    .HALF_TICKS  (HALF_TICKS),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .locRise      (rise[1]),
    .locRecent    (locRecent),
    .refAtLimit   (refAtLimit),
    .lockErr      (lockErr),
    .unlockStatus (unlockStatus)
  );

endmodule

// File: rtl/wclk_lock_checker.sv
module wclk_lock_checker #(
  parameter int HOLD_CYCLES = 2
) (
  input logic clk,
  input logic rstN,
  input logic lockErr,
  input logic unlockStatus
);

  localparam int CW = $clog2(HOLD_CYCLES + 2);
  localparam logic [CW-1:0] CMAX = CW'(HOLD_CYCLES + 1);

  logic [CW-1:0] sinceErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceErr <= CMAX;
    else if (lockErr)         sinceErr <= CW'(1);
    else if (sinceErr != CMAX) sinceErr <= sinceErr + CW'(1);
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |=> !lockErr);

  assert_status_with_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |-> unlockStatus);

  assert_rise_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    !unlockStatus |=> (!unlockStatus || lockErr));

  assert_hold_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlockStatus) |-> (sinceErr == CW'(HOLD_CYCLES)));

  assert_retrigger_R8: assert property (@(posedge clk) disable iff (!rstN)
    (unlockStatus && lockErr) |=> unlockStatus);

endmodule

bind wclk_lock_monitor wclk_lock_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .lockErr      (lockErr),
  .unlockStatus (unlockStatus)
);

// File: tb/wclk_lock_monitor_bench.sv
`timescale 1ns/1ps
module wclk_lock_monitor_bench;

  localparam int P    = 256;      // master ticks per wordclock
  localparam int N    = P / 128;  // window
  localparam int HOLD = 600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic locIn = 1'b0;
  logic lockErr, unlockStatus;

  int testsRun = 0;
  int testsFail = 0;

  int offs = 0;
  bit refRun = 1'b1;
  bit locRun = 1'b1;

  int cyc = 0;
  int errSeen = 0;
  int lowSeen = 0;
  int lastErrCyc = 0;
  int fallCyc = 0;
  logic prevStatus = 1'b0;

  always #4 clk = ~clk;

  wclk_lock_monitor #(
    .CLK_FREQ_HZ (125_000_000),
    .WORD_TICKS  (P),
    .HOLD_CYCLES (HOLD)
  ) u_wclk_lock_monitor (
    .clk          (clk),
    .rstN         (rstN),
    .refWclkIn    (refIn),
    .locWclkIn    (locIn),
    .lockErr      (lockErr),
    .unlockStatus (unlockStatus)
  );

  // stimulus generator
  initial begin
    int phase;
    phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % P;
      refIn <= refRun ? (phase < P / 2) : 1'b0;
      locIn <= locRun ? ((((phase - offs) % P + P) % P) < P / 2) : 1'b0;
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (lockErr) begin
        errSeen++;
        lastErrCyc = cyc;
      end
      if (!unlockStatus) lowSeen++;
      if (prevStatus && !unlockStatus) fallCyc = cyc;
      prevStatus = unlockStatus;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runPeriods(input int n);
    repeat (n * P) @(negedge clk);
  endtask

  task automatic measureOffset(input int d);
    int expErr;
    int mag;
    offs = d;
    runPeriods(2);
    errSeen = 0;
    lowSeen = 0;
    runPeriods(4);
    mag = (d < 0) ? -d : d;
    expErr = (mag > N) ? 4 : 0;
    if (d >= 0 && mag <= N)      check(errSeen == expErr, "R1 lag inside window", errSeen, expErr);
    else if (d < 0 && mag <= N)  check(errSeen == expErr, "R2 lead inside window", errSeen, expErr);
    else if (d > 0)              check(errSeen == expErr, "R3 lag outside window", errSeen, expErr);
    else                         check(errSeen == expErr, "R4 lead outside window", errSeen, expErr);
    if (expErr != 0) check(lowSeen == 0, "R8 retrigger keeps status high", lowSeen, 0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    check(lockErr == 1'b0, "R9 pulse low in reset", int'(lockErr), 0);
    check(unlockStatus == 1'b0, "R9 status low in reset", int'(unlockStatus), 0);
    rstN = 1'b1;

    for (int d = -10; d <= 10; d++) measureOffset(d);
    measureOffset(P / 2 - 1);
    measureOffset(-(P / 2 - 1));
    measureOffset(64);
    measureOffset(-64);

    // R7: exact hold length after the last error
    offs = 6;
    runPeriods(3);
    offs = 0;
    runPeriods(5);
    check(fallCyc - lastErrCyc == HOLD, "R7 hold length", fallCyc - lastErrCyc, HOLD);
    check(unlockStatus == 1'b0, "R7 status released", int'(unlockStatus), 0);

    // R5: local wordclock stopped
    locRun = 1'b0;
    runPeriods(2);
    errSeen = 0;
    runPeriods(4);
    check(errSeen == 4, "R5 stopped local clock", errSeen, 4);
    check(unlockStatus == 1'b1, "R8 status held while failing", int'(unlockStatus), 1);

    // R9: reset while hold timer runs
    rstN = 1'b0;
    @(negedge clk);
    check(unlockStatus == 1'b0, "R9 reset clears status", int'(unlockStatus), 0);
    check(lockErr == 1'b0, "R9 reset clears pulse", int'(lockErr), 0);
    rstN = 1'b1;

    // R10: reference stopped, local running
    locRun = 1'b1;
    refRun = 1'b0;
    runPeriods(1);
    errSeen = 0;
    runPeriods(4);
    check(errSeen == 0, "R10 no reference edges", errSeen, 0);
    check(unlockStatus == 1'b0, "R10 status stays low", int'(unlockStatus), 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule